// File: doc/BRIEF.md
# Fractional-N PLL configuration calculator

This block turns a requested VCO frequency, given in hertz, into the field values that program a fractional-N PLL fed from a 19.2 MHz reference. It decides between integer and fractional operation, derives the divider or offset field, the 16-bit fractional seed, two calibration bytes and a loop-filter resistance code. A rate with no loop-filter entry is rejected with an error flag.

A caller places the rate on `rate_hz` and pulses `start`. The block stays `busy` while one shared shift-subtract divider works through five successive divisions. It then raises `done` for one cycle with every result field valid. The results hold until the next computation finishes, and a request made while busy is dropped.

Top module: `fracn_cfg_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err` and every configuration output are 0.
- R2: When `rate_hz` is an exact multiple of 19,200,000, the block gives integer mode. `dbl_en`=0, `frac_en`=0 and `bypass_en`=1. With N = rate/19,200 and I = N/1000, `byp_div` = ((I mod 64) − 1) mod 64. `dc_off`, `seed_lo` and `seed_hi` are 0.
- R3: When the rate leaves a remainder modulo 19,200,000, the block gives fractional mode. `dbl_en`=1, `frac_en`=1, `bypass_en`=0 and `byp_div`=0. With N = floor(rate/38,400) and I = N/1000, `dc_off` = ((I mod 64) − 1) mod 64.
- R4: In fractional mode the seed is floor((N mod 1000)·65536/1000). Its bits 7:0 appear on `seed_lo` and its bits 15:8 on `seed_hi`.
- R5: Let G = N × step, where step is 38,400 in fractional mode and 19,200 in integer mode. `cal_hi` = floor(G/256,000,000) mod 256 and `cal_lo` = floor((G mod 256,000,000)/1,000,000).
- R6: `lpf_code` comes from the lowest-threshold entry whose threshold is ≥ the rate. The thresholds and codes, ascending, are: 479.5M→8, 480M→11, 575.5M→8, 576M→12, 610.5M→8, 659.5M→9, 671.5M→10, 672M→14, 708.5M→10, 750M→11. A rate equal to a threshold takes that entry.
- R7: A rate above 750,000,000 does not start the divider. `done` and `err` rise at the first clock edge after the accepted `start`, and every configuration output is 0.
- R8: For a valid rate, `busy` is high from the edge after `start` until the result. `done` is a single-cycle pulse with `busy` low. The outputs change only at the edge that raises `done`, and they otherwise hold even when `rate_hz` changes.
- R9: A `start` while `busy` is high is ignored. The pending computation finishes on the original rate, and only one `done` pulse is produced.
- R10: `busy` rises only in the cycle after `start` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation on `rate_hz` |
| rate_hz | input | 32 | Requested VCO frequency in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Rate has no loop-filter entry |
| dbl_en | output | 1 | Reference doubler enable |
| frac_en | output | 1 | Fractional (sigma-delta) mode |
| bypass_en | output | 1 | Integer bypass mode |
| byp_div | output | 6 | Integer-mode divider field |
| dc_off | output | 6 | Fractional-mode DC offset field |
| seed_lo | output | 8 | Fractional seed bits 7:0 |
| seed_hi | output | 8 | Fractional seed bits 15:8 |
| cal_lo | output | 8 | Calibration byte, MHz within 256 MHz |
| cal_hi | output | 8 | Calibration byte, 256 MHz units |
| lpf_code | output | 4 | Loop-filter resistance code |

## Verification
The bench goes after table edges: rates exactly on a threshold and one hertz past it. A design that compares with `<` instead of `<=` returns the next entry's code there, so it gives 8 instead of 11 at 480 MHz. Exact multiples such as 480 MHz and 672 MHz are set against near-misses. A design with the mode test inverted, or with the wrong scale, gives wrong divider fields and a seed that is not zero. The rate 750,000,000 is accepted and 750,000,001 is rejected, which exposes an off-by-one range check. A second `start` during a computation would, in a faulty design, restart or corrupt the result, and would show up as the wrong rate's fields or a second `done`.

// File: rtl/fracn_cfg_calc.sv
module fracn_cfg_calc #(
  parameter int unsigned REF_HZ = 19_200_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] rate_hz,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        dbl_en,
  output logic        frac_en,
  output logic        bypass_en,
  output logic [5:0]  byp_div,
  output logic [5:0]  dc_off,
  output logic [7:0]  seed_lo,
  output logic [7:0]  seed_hi,
  output logic [7:0]  cal_lo,
  output logic [7:0]  cal_hi,
  output logic [3:0]  lpf_code
);
  localparam int unsigned STEP_F = REF_HZ / 500;
  localparam int unsigned STEP_I = REF_HZ / 1000;
  localparam int unsigned NTAB   = 10;
  localparam logic [31:0] THR [NTAB] = '{32'd479_500_000, 32'd480_000_000, 32'd575_500_000,
    32'd576_000_000, 32'd610_500_000, 32'd659_500_000, 32'd671_500_000, 32'd672_000_000,
    32'd708_500_000, 32'd750_000_000};
  localparam logic [3:0] CODE [NTAB] = '{4'd8, 4'd11, 4'd8, 4'd12, 4'd8, 4'd9, 4'd10,
    4'd14, 4'd10, 4'd11};

  typedef enum logic [1:0] {IDLE, DIV, LOAD} st_t;
  st_t st;
  logic [2:0]  stage;
  logic [4:0]  cnt;
  logic [31:0] acc, quo, dvs, divfb_r;
  logic [15:0] seed_r;
  logic [5:0]  int_r;
  logic [3:0]  lpf_r;
  logic        frac_r;

  logic        lpf_hit;
  logic [3:0]  lpf_val;
  always_comb begin
    lpf_hit = 1'b0;
    lpf_val = '0;
    for (int i = NTAB - 1; i >= 0; i--)
      if (rate_hz <= THR[i]) begin
        lpf_hit = 1'b1;
        lpf_val = CODE[i];
      end
  end

  wire [32:0] trial = {acc, quo[31]};
  wire        ge    = trial >= {1'b0, dvs};
  wire [31:0] gen   = 32'(divfb_r * (frac_r ? STEP_F : STEP_I));

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; stage <= '0; cnt <= '0;
      acc <= '0; quo <= '0; dvs <= '0; divfb_r <= '0;
      seed_r <= '0; int_r <= '0; lpf_r <= '0; frac_r <= 1'b0;
      done <= 1'b0; err <= 1'b0; dbl_en <= 1'b0; frac_en <= 1'b0; bypass_en <= 1'b0;
      byp_div <= '0; dc_off <= '0; seed_lo <= '0; seed_hi <= '0;
      cal_lo <= '0; cal_hi <= '0; lpf_code <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (!lpf_hit) begin
            done <= 1'b1; err <= 1'b1; dbl_en <= 1'b0; frac_en <= 1'b0;
            bypass_en <= 1'b0; byp_div <= '0; dc_off <= '0; seed_lo <= '0;
            seed_hi <= '0; cal_lo <= '0; cal_hi <= '0; lpf_code <= '0;
          end else begin
            lpf_r <= lpf_val;
            acc <= '0; quo <= rate_hz; dvs <= REF_HZ;
            cnt <= '0; stage <= '0; st <= DIV;
          end
        end
        DIV: begin
          acc <= ge ? 32'(trial - {1'b0, dvs}) : trial[31:0];
          quo <= {quo[30:0], ge};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd31) st <= LOAD;
        end
        default: begin
          cnt <= '0;
          stage <= stage + 3'd1;
          st <= DIV;
          case (stage)
            3'd0: begin
              frac_r <= (acc != 0);
              dvs <= (acc != 0) ? STEP_F : STEP_I;
              quo <= rate_hz_q;
              acc <= '0;
            end
            3'd1: begin
              divfb_r <= quo;
              dvs <= 32'd1000; acc <= '0;
            end
            3'd2: begin
              int_r <= quo[5:0] - 6'd1;
              quo <= {acc[15:0], 16'd0}; acc <= '0;
            end
            3'd3: begin
              seed_r <= quo[15:0];
              quo <= gen; dvs <= 32'd1_000_000; acc <= '0;
            end
            default: begin
              st <= IDLE; done <= 1'b1; err <= 1'b0;
              dbl_en <= frac_r; frac_en <= frac_r; bypass_en <= !frac_r;
              byp_div <= frac_r ? 6'd0 : int_r;
              dc_off  <= frac_r ? int_r : 6'd0;
              seed_lo <= frac_r ? seed_r[7:0] : 8'd0;
              seed_hi <= frac_r ? seed_r[15:8] : 8'd0;
              cal_hi <= quo[15:8]; cal_lo <= quo[7:0];
              lpf_code <= lpf_r;
            end
          endcase
        end
      endcase
    end
  end

  logic [31:0] rate_hz_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rate_hz_q <= '0;
    else if (st == IDLE && start) rate_hz_q <= rate_hz;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({err, dbl_en, frac_en, bypass_en, byp_div, dc_off,
                       seed_lo, seed_hi, cal_lo, cal_hi, lpf_code}));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R6
  lpf_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> (lpf_code != 4'd0));
endmodule

// File: tb/fracn_cfg_calc_test.sv
module fracn_cfg_calc_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] rate_hz = '0;
  logic busy, done, err, dbl_en, frac_en, bypass_en;
  logic [5:0] byp_div, dc_off;
  logic [7:0] seed_lo, seed_hi, cal_lo, cal_hi;
  logic [3:0] lpf_code;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fracn_cfg_calc uut (.clk, .rst_n, .start, .rate_hz, .busy, .done, .err, .dbl_en,
    .frac_en, .bypass_en, .byp_div, .dc_off, .seed_lo, .seed_hi, .cal_lo, .cal_hi, .lpf_code);

  longint e_err, e_dbl, e_frac, e_byp, e_bdiv, e_dc, e_slo, e_shi, e_clo, e_chi, e_lpf;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(input longint r);
    longint step, n, ip, fld, sd, g;
    e_err = 0; e_dbl = 0; e_frac = 0; e_byp = 0; e_bdiv = 0; e_dc = 0;
    e_slo = 0; e_shi = 0; e_clo = 0; e_chi = 0; e_lpf = 0;
    if      (r <= 479_500_000) e_lpf = 8;
    else if (r <= 480_000_000) e_lpf = 11;
    else if (r <= 575_500_000) e_lpf = 8;
    else if (r <= 576_000_000) e_lpf = 12;
    else if (r <= 610_500_000) e_lpf = 8;
    else if (r <= 659_500_000) e_lpf = 9;
    else if (r <= 671_500_000) e_lpf = 10;
    else if (r <= 672_000_000) e_lpf = 14;
    else if (r <= 708_500_000) e_lpf = 10;
    else if (r <= 750_000_000) e_lpf = 11;
    else begin e_err = 1; e_lpf = 0; return; end
    if (r % 19_200_000 != 0) begin e_frac = 1; e_dbl = 1; step = 38_400; end
    else begin e_byp = 1; step = 19_200; end
    n = r / step;
    ip = n / 1000;
    fld = ((ip % 64) - 1 + 64) % 64;
    if (e_frac != 0) begin
      e_dc = fld;
      sd = ((n % 1000) * 65536) / 1000;
      e_slo = sd % 256; e_shi = sd / 256;
    end else e_bdiv = fld;
    g = n * step;
    e_chi = (g / 256_000_000) % 256;
    e_clo = (g % 256_000_000) / 1_000_000;
  endtask

  task automatic compare(input string req);
    chk(req, "err", err, e_err);
    chk("R2/R3", "dbl_en", dbl_en, e_dbl);
    chk("R3", "frac_en", frac_en, e_frac);
    chk("R2", "bypass_en", bypass_en, e_byp);
    chk("R2", "byp_div", byp_div, e_bdiv);
    chk("R3", "dc_off", dc_off, e_dc);
    chk("R4", "seed_lo", seed_lo, e_slo);
    chk("R4", "seed_hi", seed_hi, e_shi);
    chk("R5", "cal_lo", cal_lo, e_clo);
    chk("R5", "cal_hi", cal_hi, e_chi);
    chk("R6", "lpf_code", lpf_code, e_lpf);
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk); rate_hz = r; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk(req, "done seen", done, 1);
  endtask

  task automatic run(input logic [31:0] r, input string req);
    model(r);
    pulse(r);
    chk("R8", "busy after start", busy, 1);
    wait_done(req);
    chk("R8", "busy at done", busy, 0);
    compare(req);
    @(negedge clk);
    chk("R8", "done single cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0); chk("R1", "err", err, 0);
    chk("R1", "cfg", {dbl_en, frac_en, bypass_en, byp_div, dc_off, seed_lo, seed_hi,
                      cal_lo, cal_hi, lpf_code}, 0);
  endtask

  task automatic t_integer;
    run(32'd480_000_000, "R2");
    run(32'd672_000_000, "R2");
    run(32'd364_800_000, "R2");
  endtask

  task automatic t_fraction;
    run(32'd500_000_000, "R3");
    run(32'd350_000_000, "R4");
    run(32'd612_345_678, "R5");
  endtask

  task automatic t_lpf_edges;
    run(32'd479_500_000, "R6");
    run(32'd480_000_001, "R6");
    run(32'd671_500_001, "R6");
    run(32'd750_000_000, "R6");
  endtask

  task automatic t_error;
    model(32'd750_000_001);
    pulse(32'd750_000_001);
    chk("R7", "done next edge", done, 1);
    chk("R7", "busy", busy, 0);
    compare("R7");
  endtask

  task automatic t_hold;
    logic [47:0] snap;
    run(32'd500_000_000, "R8");
    snap = {seed_hi, seed_lo, cal_hi, cal_lo, lpf_code, dc_off, dbl_en, frac_en};
    rate_hz = 32'd672_000_000;
    repeat (20) @(negedge clk);
    chk("R8", "outputs held", {seed_hi, seed_lo, cal_hi, cal_lo, lpf_code, dc_off, dbl_en, frac_en}, snap);
  endtask

  task automatic t_busy_start;
    int dones = 0;
    model(32'd612_345_678);
    pulse(32'd612_345_678);
    repeat (40) @(negedge clk);
    pulse(32'd480_000_000);
    rate_hz = 32'd700_000_000;
    for (int k = 0; k < 400; k++) begin
      if (done) begin
        dones++;
        if (dones == 1) compare("R9");
      end
      @(negedge clk);
    end
    chk("R9", "done pulses", dones, 1);
    chk("R9", "idle after", busy, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    summary;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_integer;
    t_fraction;
    t_lpf_edges;
    t_error;
    t_hold;
    t_busy_start;
    summary;
  end
endmodule